// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Command Front-End

This block is the device side of the serial port of a paged flash memory that has two page-sized SRAM staging buffers of 264 bytes each. The host drives chip select, a serial clock and a serial data line. The block oversamples all three into a faster system clock. It gathers an 8-bit command code and a 24-bit address field, most significant bit first, and then takes one of three paths. It serves buffer writes, buffer reads and status reads on its own. It passes page-level array commands to a separate sequencer as a single-cycle pulse when chip select is released. It ignores every other command code.

Read data and status bits change on the falling serial clock, so the host samples them on the rising edge. The output enable drops as soon as chip select is deasserted. The sequencer can lock one buffer while a timed array operation uses it. Reads and writes aimed at that buffer are then refused, and the other buffer stays fully usable.

Top module: `dbf_front`

## Requirements
- R1: After reset, `so_oe` and `cmd_valid` are both 0.
- R2: Command 0x84 followed by 24 address bits writes each following complete data byte into buffer A. The start byte is the low 9 address bits, and the upper 15 bits are ignored. Command 0x54 with the same address layout, followed by 8 ignored bits, returns the stored bytes on `so_data` in order, MSB first.
- R3: Commands 0x87 (write) and 0x56 (read) do the same for buffer B. The two buffers are independent, so a write to one never alters the other.
- R4: During buffer access, the byte pointer advances from 263 to 0 in the same buffer and never leaves the range 0..263.
- R5: `so_oe` stays 0 during the command, address and read gap bits. The first read data bit is presented after the falling clock edge that ends the gap.
- R6: Command 0x57 streams the status byte repeatedly while select stays low. Each bit is taken live. Bit 7 is ready (the inverse of `busy`), bit 6 is `cmp_miss`, bits 5:3 are 0,1,1, and bits 2:0 read as 0.
- R7: The serial clock may idle low (mode 0) or high (mode 3) when select falls. Input is always taken on the rising edge.
- R8: Raising chip select ends any command. Within a few system clocks `so_oe` is 0, and a partly shifted write byte is discarded.
- R9: An unrecognised command code is ignored until select rises. `so_oe` stays 0, no array command is issued, and the next command decodes normally.
- R10: While `lock_en` is 1, reads of buffer `lock_buf` (0 = A, 1 = B) leave `so_oe` at 0 and writes to it are dropped. The other buffer works normally.
- R11: Array command codes (0x53, 0x55, 0x58, 0x59, 0x60, 0x61, 0x83, 0x86, 0x88, 0x89) that carry all 24 address bits produce exactly one `cmd_valid` pulse after select rises. `cmd_op` and `cmd_addr` then hold the code and address. A shorter frame produces no pulse.
- R12: A start byte address of 264 or more is folded by subtracting 264.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Host serial clock, asynchronous |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| si | input | 1 | Host serial data in |
| so_data | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so_data (0 = high impedance) |
| busy | input | 1 | Sequencer busy with a timed operation |
| cmp_miss | input | 1 | Last compare found a difference |
| lock_en | input | 1 | A buffer is held by the sequencer |
| lock_buf | input | 1 | Which buffer is held |
| cmd_valid | output | 1 | One-cycle array command strobe |
| cmd_op | output | 8 | Array command code |
| cmd_addr | output | 24 | Array command address field |

## Verification
The checker enforces four rules on every cycle. The output enable must be low once select has been high for a few cycles. The command strobe must never last longer than one cycle. A locked buffer must be neither driven onto the output nor written. The byte pointer must stay within 0..263. The bench scenarios cover the rest, because only complete frames can show these behaviours. Those behaviours are data round trips through both buffers, the wrap at 263 and the fold of large start addresses, live status repeats, mode 3 framing, discarded partial bytes, ignored codes, and the exact content of the handed-off array command.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    localparam logic [7:0] OP_WR_A  = 8'h84;
    localparam logic [7:0] OP_WR_B  = 8'h87;
    localparam logic [7:0] OP_RD_A  = 8'h54;
    localparam logic [7:0] OP_RD_B  = 8'h56;
    localparam logic [7:0] OP_STAT  = 8'h57;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPCODE, ST_ADDR, ST_GAP, ST_RDATA,
        ST_WDATA, ST_STAT, ST_ARRAY, ST_IGNORE
    } st_e;

    typedef enum logic [2:0] {
        K_NONE, K_STAT, K_READ, K_WRITE, K_ARRAY
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  sel;
    } dec_t;

    function automatic dec_t decode_op(input logic [7:0] op);
        dec_t d;
        d.kind = K_NONE;
        d.sel  = 1'b0;
        case (op)
            OP_STAT: d.kind = K_STAT;
            OP_RD_A: d.kind = K_READ;
            OP_RD_B: begin d.kind = K_READ;  d.sel = 1'b1; end
            OP_WR_A: d.kind = K_WRITE;
            OP_WR_B: begin d.kind = K_WRITE; d.sel = 1'b1; end
            8'h53, 8'h58, 8'h60, 8'h83, 8'h88: d.kind = K_ARRAY;
            8'h55, 8'h59, 8'h61, 8'h86, 8'h89: begin d.kind = K_ARRAY; d.sel = 1'b1; end
            default: d.kind = K_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbf_bufs.sv
module dbf_bufs #(
    parameter int BUF_BYTES = 264,
    localparam int PW       = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wsel,
    input  logic          rsel,
    input  logic [PW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] bank_rd [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [7:0] mem [BUF_BYTES];
        always_ff @(posedge clk) begin
            if (we && (wsel == g[0])) mem[addr] <= wdata;
        end
        assign bank_rd[g] = mem[addr];
    end

    assign rdata = bank_rd[rsel];
endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
    import dbf_pkg::*;
#(
    parameter int         BUF_BYTES = 264,
    parameter int         ADDR_BITS = 24,
    parameter logic [2:0] DENSITY   = 3'b011,
    localparam int        PW        = $clog2(BUF_BYTES),
    localparam int        CW        = $clog2(ADDR_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck_q,
    input  logic                 cs_q,
    input  logic                 si_q,
    input  logic                 busy,
    input  logic                 cmp_miss,
    input  logic                 lock_en,
    input  logic                 lock_buf,
    input  logic [7:0]           rdata,
    output logic                 mem_we,
    output logic                 mem_buf,
    output logic [PW-1:0]        mem_addr,
    output logic [7:0]           mem_wdata,
    output logic                 so_bit,
    output logic                 so_oe,
    output logic                 cmd_valid,
    output logic [7:0]           cmd_op,
    output logic [ADDR_BITS-1:0] cmd_addr,
    output logic                 rd_active
);
    localparam logic [PW-1:0]  LAST     = PW'(BUF_BYTES - 1);
    localparam logic [PW:0]    LEN      = (PW+1)'(BUF_BYTES);
    localparam logic [CW-1:0]  BYTE_END = CW'(7);
    localparam logic [CW-1:0]  ADDR_END = CW'(ADDR_BITS - 1);

    st_e                  st, st_n;
    logic [CW-1:0]        cnt;
    logic [ADDR_BITS-1:0] sh;
    logic [7:0]           op_r;
    logic [ADDR_BITS-1:0] addr_r;
    kind_e                kind_r;
    logic                 buf_r;
    logic [PW-1:0]        ptr;
    logic [7:0]           rd_byte;
    logic [2:0]           bidx;
    logic                 so_en;
    logic                 sck_d, cs_d;

    logic                 sck_rise, sck_fall, cs_rise, locked;
    logic [7:0]           op_now;
    logic [ADDR_BITS-1:0] addr_now;
    logic [PW-1:0]        start_raw, start_fold;
    logic [7:0]           stat_byte;
    dec_t                 dec_now;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign sck_rise   = sck_q & ~sck_d;
    assign sck_fall   = ~sck_q & sck_d;
    assign cs_rise    = cs_q & ~cs_d;
    assign op_now     = {sh[6:0], si_q};
    assign addr_now   = {sh[ADDR_BITS-2:0], si_q};
    assign dec_now    = decode_op(op_now);
    assign start_raw  = addr_now[PW-1:0];
    assign start_fold = ({1'b0, start_raw} >= LEN) ? PW'({1'b0, start_raw} - LEN) : start_raw;
    assign stat_byte  = {~busy, cmp_miss, DENSITY, 3'b000};
    assign locked     = lock_en && (lock_buf == buf_r);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        if (cs_q) begin
            st_n = ST_IDLE;
        end else if (st == ST_IDLE) begin
            st_n = ST_OPCODE;
        end else if (sck_rise) begin
            unique case (st)
                ST_OPCODE: if (cnt == BYTE_END) begin
                    unique case (dec_now.kind)
                        K_STAT:                   st_n = ST_STAT;
                        K_READ, K_WRITE, K_ARRAY: st_n = ST_ADDR;
                        default:                  st_n = ST_IGNORE;
                    endcase
                end
                ST_ADDR: if (cnt == ADDR_END) begin
                    unique case (kind_r)
                        K_READ:  st_n = ST_GAP;
                        K_WRITE: st_n = ST_WDATA;
                        default: st_n = ST_ARRAY;
                    endcase
                end
                ST_GAP: if (cnt == BYTE_END) st_n = ST_RDATA;
                default: st_n = st;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d     <= 1'b0;
            cs_d      <= 1'b1;
            cnt       <= '0;
            sh        <= '0;
            op_r      <= '0;
            addr_r    <= '0;
            kind_r    <= K_NONE;
            buf_r     <= 1'b0;
            ptr       <= '0;
            rd_byte   <= '0;
            bidx      <= 3'd7;
            so_bit    <= 1'b0;
            so_en     <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            sck_d     <= sck_q;
            cs_d      <= cs_q;
            cmd_valid <= cs_rise && (st == ST_ARRAY);
            if (cs_q) begin
                so_en <= 1'b0;
                cnt   <= '0;
            end else begin
                if (sck_rise && st != ST_IDLE) sh <= addr_now;
                if (st != st_n)
                    cnt <= '0;
                else if (sck_rise)
                    cnt <= (st == ST_WDATA && cnt == BYTE_END) ? '0 : cnt + 1'b1;
                unique case (st)
                    ST_OPCODE: if (sck_rise && cnt == BYTE_END) begin
                        op_r   <= op_now;
                        kind_r <= dec_now.kind;
                        buf_r  <= dec_now.sel;
                        bidx   <= 3'd7;
                    end
                    ST_ADDR: if (sck_rise && cnt == ADDR_END) begin
                        addr_r <= addr_now;
                        ptr    <= start_fold;
                    end
                    ST_GAP: if (sck_rise && cnt == BYTE_END) begin
                        rd_byte <= rdata;
                        ptr     <= ptr_inc(ptr);
                        bidx    <= 3'd7;
                    end
                    ST_RDATA: if (sck_fall) begin
                        so_bit <= rd_byte[bidx];
                        so_en  <= 1'b1;
                        if (bidx == 3'd0) begin
                            rd_byte <= rdata;
                            ptr     <= ptr_inc(ptr);
                            bidx    <= 3'd7;
                        end else begin
                            bidx <= bidx - 1'b1;
                        end
                    end
                    ST_WDATA: if (sck_rise && cnt == BYTE_END) ptr <= ptr_inc(ptr);
                    ST_STAT: if (sck_fall) begin
                        so_bit <= stat_byte[bidx];
                        so_en  <= 1'b1;
                        bidx   <= bidx - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_active = (st == ST_RDATA);
    assign so_oe     = so_en && !cs_q && !(rd_active && locked);
    assign mem_we    = !cs_q && sck_rise && (st == ST_WDATA) && (cnt == BYTE_END) && !locked;
    assign mem_buf   = buf_r;
    assign mem_addr  = ptr;
    assign mem_wdata = op_now;
    assign cmd_op    = op_r;
    assign cmd_addr  = addr_r;
endmodule

// File: rtl/dbf_front.sv
module dbf_front
    import dbf_pkg::*;
#(
    parameter int BUF_BYTES   = 264,
    parameter int ADDR_BITS   = 24,
    parameter int SYNC_STAGES = 2,
    localparam int PW         = $clog2(BUF_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 si,
    output logic                 so_data,
    output logic                 so_oe,
    input  logic                 busy,
    input  logic                 cmp_miss,
    input  logic                 lock_en,
    input  logic                 lock_buf,
    output logic                 cmd_valid,
    output logic [7:0]           cmd_op,
    output logic [ADDR_BITS-1:0] cmd_addr
);
    logic [2:0]    pins_q;
    logic          mem_we, mem_buf, rd_active;
    logic [PW-1:0] mem_addr;
    logic [7:0]    mem_wdata, rdata;

    dbf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sck, cs_n, si}),
        .q       (pins_q)
    );

    dbf_ctrl #(.BUF_BYTES(BUF_BYTES), .ADDR_BITS(ADDR_BITS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_q     (pins_q[2]),
        .cs_q      (pins_q[1]),
        .si_q      (pins_q[0]),
        .busy      (busy),
        .cmp_miss  (cmp_miss),
        .lock_en   (lock_en),
        .lock_buf  (lock_buf),
        .rdata     (rdata),
        .mem_we    (mem_we),
        .mem_buf   (mem_buf),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .so_bit    (so_data),
        .so_oe     (so_oe),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .rd_active (rd_active)
    );

    dbf_bufs #(.BUF_BYTES(BUF_BYTES)) u_bufs (
        .clk   (clk),
        .we    (mem_we),
        .wsel  (mem_buf),
        .rsel  (mem_buf),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rdata)
    );
endmodule

// File: rtl/dbf_front_chk.sv
module dbf_front_chk #(
    parameter int BUF_BYTES = 264,
    localparam int PW       = $clog2(BUF_BYTES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          so_oe,
    input logic          cmd_valid,
    input logic          lock_en,
    input logic          lock_buf,
    input logic          rd_active,
    input logic          mem_we,
    input logic          mem_buf,
    input logic [PW-1:0] mem_addr
);
    AST_OE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe); // R8

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R11

    AST_LOCK_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && lock_en && (lock_buf == mem_buf)) |-> !so_oe); // R10

    AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && lock_en) |-> (mem_buf != lock_buf)); // R10

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr < PW'(BUF_BYTES)); // R4
endmodule

bind dbf_front dbf_front_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .so_oe     (so_oe),
    .cmd_valid (cmd_valid),
    .lock_en   (lock_en),
    .lock_buf  (lock_buf),
    .rd_active (rd_active),
    .mem_we    (mem_we),
    .mem_buf   (mem_buf),
    .mem_addr  (mem_addr)
);

// File: tb/dbf_front_tb.sv
`timescale 1ns/1ps
module dbf_front_tb;
    localparam int NB   = 264;
    localparam int HALF = 64;

    logic clk = 0, rst_n = 0;
    logic sck = 0, cs_n = 1, si = 0;
    logic busy = 0, cmp_miss = 0, lock_en = 0, lock_buf = 0;
    logic so_data, so_oe, cmd_valid;
    logic [7:0]  cmd_op;
    logic [23:0] cmd_addr;

    int total = 0, bad = 0;
    bit m3 = 0, done = 0;
    logic [7:0] ref_mem [2][NB];
    bit         ref_ok  [2][NB];
    logic [7:0] wdat [64];
    int n_cmd = 0;
    logic [7:0]  last_op;
    logic [23:0] last_addr;
    int hi_cnt = 0;

    always #4 clk = ~clk;

    dbf_front u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so_data(so_data), .so_oe(so_oe), .busy(busy), .cmp_miss(cmp_miss),
        .lock_en(lock_en), .lock_buf(lock_buf), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n && cmd_valid) begin
        n_cmd++;
        last_op   <= cmd_op;
        last_addr <= cmd_addr;
    end

    // per-clock model comparison: deselected port must not drive (R8)
    always @(negedge clk) if (rst_n) begin
        hi_cnt = cs_n ? hi_cnt + 1 : 0;
        if (hi_cnt >= 6) chk(so_oe == 1'b0, "R8 idle oe", int'(so_oe), 0);
    end

    task automatic xbit(input logic b, output logic o, output bit oe);
        if (m3) sck = 0;
        si = b;
        #(HALF);
        o  = so_data;
        oe = so_oe;
        sck = 1;
        #(HALF);
        if (!m3) sck = 0;
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r, output int n_oe);
        n_oe = 0;
        for (int i = 7; i >= 0; i--) begin
            logic o; bit oe;
            xbit(d[i], o, oe);
            r[i] = o;
            if (oe) n_oe++;
        end
    endtask

    task automatic cs_start();
        sck = m3;
        #(HALF);
        cs_n = 0;
        #(HALF);
    endtask

    task automatic cs_stop();
        #(HALF);
        cs_n = 1;
        #(HALF * 3);
    endtask

    function automatic int fold(input int a);
        return (a >= NB) ? a - NB : a;
    endfunction

    task automatic send_hdr(input logic [7:0] op, input logic [8:0] start, output int oe_sum);
        logic [7:0] r; int n;
        oe_sum = 0;
        xbyte(op, r, n);                      oe_sum += n;
        xbyte(8'hC3, r, n);                   oe_sum += n;
        xbyte({7'h2A, start[8]}, r, n);       oe_sum += n;
        xbyte(start[7:0], r, n);              oe_sum += n;
    endtask

    task automatic buf_write(input bit sel, input int start, input int cnt);
        int p, s; logic [7:0] r; int n;
        p = fold(start);
        cs_start();
        send_hdr(sel ? 8'h87 : 8'h84, 9'(start), s);
        for (int k = 0; k < cnt; k++) begin
            xbyte(wdat[k], r, n);
            if (!(lock_en && lock_buf == sel)) begin
                ref_mem[sel][p] = wdat[k];
                ref_ok[sel][p]  = 1;
            end
            p = (p == NB - 1) ? 0 : p + 1;
        end
        cs_stop();
    endtask

    task automatic buf_read(input bit sel, input int start, input int cnt, input string req);
        int p, s, n; logic [7:0] r;
        bit lk;
        lk = lock_en && lock_buf == sel;
        p = fold(start);
        cs_start();
        send_hdr(sel ? 8'h56 : 8'h54, 9'(start), s);
        xbyte(8'h00, r, n); s += n;
        chk(s == 0, "R5 no drive before data", s, 0);
        for (int k = 0; k < cnt; k++) begin
            xbyte(8'h00, r, n);
            if (lk) chk(n == 0, req, n, 0);
            else begin
                chk(n == 8, "R5 drive during data", n, 8);
                if (ref_ok[sel][p]) chk(r == ref_mem[sel][p], req, r, ref_mem[sel][p]);
            end
            p = (p == NB - 1) ? 0 : p + 1;
        end
        cs_stop();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(1_500_000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [7:0] r; int n, c0;
        for (int b = 0; b < 2; b++) for (int a = 0; a < NB; a++) ref_ok[b][a] = 0;
        repeat (5) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(so_oe == 0, "R1 oe", int'(so_oe), 0);
        chk(cmd_valid == 0, "R1 cmd", int'(cmd_valid), 0);

        for (int k = 0; k < 64; k++) wdat[k] = 8'(k * 37 + 5);
        buf_write(0, 0, 8);
        buf_read(0, 0, 8, "R2");

        for (int k = 0; k < 64; k++) wdat[k] = 8'(k * 11 + 200);
        buf_write(1, 0, 8);
        buf_read(1, 0, 8, "R3");
        buf_read(0, 0, 4, "R3 other buffer");

        for (int k = 0; k < 64; k++) wdat[k] = 8'(8'hE0 + k);
        buf_write(0, 262, 4);
        buf_read(0, 262, 4, "R4 wrap");
        buf_read(0, 0, 2, "R4 wrap low");

        wdat[0] = 8'h6D;
        buf_write(1, 300, 1);
        buf_read(1, 36, 1, "R12 fold");

        // status stream with live changes (R6)
        busy = 1; cmp_miss = 1;
        cs_start();
        xbyte(8'h57, r, n);
        xbyte(8'h00, r, n);
        chk(r == 8'h58 && n == 8, "R6 status busy", r, 8'h58);
        xbyte(8'h00, r, n);
        chk(r == 8'h58, "R6 status repeat", r, 8'h58);
        busy = 0; cmp_miss = 0;
        xbyte(8'h00, r, n);
        xbyte(8'h00, r, n);
        chk(r == 8'h98, "R6 status live", r, 8'h98);
        cs_stop();

        // mode 3 framing (R7)
        m3 = 1;
        for (int k = 0; k < 64; k++) wdat[k] = 8'(8'h3A ^ k);
        buf_write(1, 100, 3);
        buf_read(1, 100, 3, "R7 mode3");
        cs_start();
        xbyte(8'h57, r, n);
        xbyte(8'h00, r, n);
        chk(r == 8'h98, "R7 mode3 status", r, 8'h98);
        cs_stop();
        m3 = 0;

        // partial byte discarded (R8)
        wdat[0] = 8'h11; wdat[1] = 8'h22;
        buf_write(1, 10, 2);
        cs_start();
        send_hdr(8'h87, 9'd10, n);
        xbyte(8'hEE, r, n);
        for (int i = 0; i < 4; i++) begin
            logic o; bit oe;
            xbit(1'b0, o, oe);
        end
        cs_stop();
        ref_mem[1][10] = 8'hEE;
        buf_read(1, 10, 2, "R8 partial");

        // unrecognised code (R9)
        c0 = n_cmd;
        cs_start();
        xbyte(8'h3C, r, n);
        begin
            int s = 0;
            for (int k = 0; k < 4; k++) begin xbyte(8'hFF, r, n); s += n; end
            chk(s == 0, "R9 no drive", s, 0);
        end
        cs_stop();
        chk(n_cmd == c0, "R9 no command", n_cmd, c0);
        buf_read(0, 0, 2, "R9 next command");

        // lock (R10)
        lock_en = 1; lock_buf = 0;
        wdat[0] = 8'hAB; wdat[1] = 8'hCD;
        buf_write(0, 0, 2);
        buf_read(0, 0, 2, "R10 locked read");
        wdat[0] = 8'h5E;
        buf_write(1, 50, 1);
        buf_read(1, 50, 1, "R10 other buffer");
        lock_en = 0;
        buf_read(0, 0, 2, "R10 write dropped");

        // array handoff (R11)
        c0 = n_cmd;
        cs_start();
        xbyte(8'h83, r, n); xbyte(8'h05, r, n); xbyte(8'hA3, r, n); xbyte(8'hC7, r, n);
        cs_stop();
        chk(n_cmd == c0 + 1, "R11 one pulse", n_cmd, c0 + 1);
        chk(last_op == 8'h83, "R11 code", last_op, 8'h83);
        chk(last_addr == 24'h05A3C7, "R11 address", last_addr, 24'h05A3C7);
        cs_start();
        xbyte(8'h86, r, n); xbyte(8'h01, r, n); xbyte(8'h02, r, n);
        cs_stop();
        chk(n_cmd == c0 + 1, "R11 short frame", n_cmd, c0 + 1);

        finish_up();
    end
endmodule